// File: doc/BRIEF.md
# Multi-Channel Window Limit Watchdog

This block holds a lower and an upper 8-bit limit for each of eight sampled channels and checks the channel samples against those windows without the host taking part. Samples come in over a valid/ready channel interface. The block names the channel it wants on `smp_chan_o`. The host drives a simple command port. Through it the host writes or reads limits singly or as a 16-entry burst, asks for one conversion, starts continuous conversion, starts the watchdog scan, or reads and clears the violation flags.

In watchdog mode the block visits channels in increasing order, starting at channel 0 and wrapping. Each check takes a fixed compare window. At the first channel whose sample leaves its window, the block records the channel and crossing type in a tag register and sets the top status bit. It then checks each of the following seven channels once. It marks each further violation in the status register, at a bit position counted from the failing channel. After that pass it drives the active-low interrupt. The host lines the status bits up with channel numbers by rotating left by (tag channel + 1) mod 8.

Top module: `win_watch`

## Requirements
- R1: Reset state. After reset, `irq_no` is high, `rsp_valid_o` and `conv_valid_o` are low, `cmd_ready_o` is high, and all sixteen limits read as 0.
- R2: Single limit access. Op 1 writes `cmd_wdata_i` into the limit that `cmd_chan_i` and `cmd_sel_i` select (sel 1 = upper, 0 = lower). Op 3 returns that limit unchanged on one `rsp_valid_o` beat, with the value in `rsp_data_o[7:0]` and the upper bits 0.
- R3: Burst write. Op 2 is followed by 16 accepted command beats whose `cmd_wdata_i` fill entry k = 0..15. Entry k is channel k>>1, with the lower limit for even k and the upper limit for odd k. The op field of these beats is ignored.
- R4: Burst read. Op 4 returns 16 response beats in the same entry order as R3.
- R5: Single conversion. Op 5 requests channel `cmd_chan_i` on `smp_chan_o`. The accepted sample appears as exactly one `conv_valid_o` beat carrying that channel and data. The block then goes idle.
- R6: Auto conversion. Op 6 requests channels 0,1,…,7,0,… and emits one conversion beat per accepted sample. It stops when a new command is accepted.
- R7: Watchdog scan. Op 0 scans the channels in increasing order from 0, wrapping. While no sample violates, `irq_no` stays high. A command accepted during this scan ends it.
- R8: A sample violates when it is above its upper limit or below its lower limit. A sample equal to either limit does not violate.
- R9: On the first violation at channel f, status bit 7 is set and the tag (`rsp_data_o[11:8]` of a flag read) holds f in bits [2:0]. Tag bit 3 is 1 when the sample is above the upper limit; this case wins when both limits are crossed.
- R10: After the first violation, channels f+1 … f+7 (mod 8) are each checked once. Status bit j is set if and only if channel (f+1+j) mod 8 violates. `irq_no` then goes low and sampling stops.
- R11: While `irq_no` is low, commands other than op 7 are accepted and have no effect: no response, no conversion, no limit change, and `irq_no` stays low.
- R12: Op 7 returns {tag, status} on `rsp_data_o[11:0]`, clears both registers, releases `irq_no` and returns the block to idle.
- R13: Each watchdog check takes 4 cycles after sample acceptance (2 per limit). With `smp_valid_i` held high, consecutive watchdog sample handshakes are 5 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command beat valid |
| cmd_ready_o | output | 1 | Command beat accepted when high with valid |
| cmd_op_i | input | 3 | Operation code |
| cmd_chan_i | input | 3 | Channel for single access or conversion |
| cmd_sel_i | input | 1 | Limit select, 1 upper, 0 lower |
| cmd_wdata_i | input | 8 | Limit write data |
| rsp_valid_o | output | 1 | Response beat |
| rsp_data_o | output | 12 | Limit value or {tag, status} |
| smp_valid_i | input | 1 | Sample valid |
| smp_ready_o | output | 1 | Sample requested |
| smp_chan_o | output | 3 | Channel being requested |
| smp_data_i | input | 8 | Sample value |
| conv_valid_o | output | 1 | Conversion result beat |
| conv_chan_o | output | 3 | Channel of the result |
| conv_data_o | output | 8 | Sample value of the result |
| irq_no | output | 1 | Active-low interrupt |

## Verification
A wrong scan pointer or pass counter shows up as a mismatch in the channel order on `smp_chan_o` within one check window, or as a status bit that rotates onto the wrong channel at the flag read. A mistimed compare slot moves the handshake spacing off 5 cycles on the next sample. A corrupt limit entry is caught by the next readback, or by a tag or status mismatch after one watchdog pass. Flag registers that are not cleared show up on the very next flag read.

// File: rtl/win_watch_pkg.sv
package win_watch_pkg;
  typedef enum logic [2:0] {
    OP_WATCH     = 3'd0,
    OP_WR_ONE    = 3'd1,
    OP_WR_ALL    = 3'd2,
    OP_RD_ONE    = 3'd3,
    OP_RD_ALL    = 3'd4,
    OP_CONV_ONE  = 3'd5,
    OP_CONV_AUTO = 3'd6,
    OP_RD_FLAGS  = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WRALL, S_RDALL, S_CONV1, S_AUTO, S_W_REQ, S_W_CMP, S_FLAG
  } st_e;
endpackage

// File: rtl/win_limit_rf.sv
module win_limit_rf #(
  parameter int NCH = 8,
  parameter int DW  = 8,
  localparam int CW   = $clog2(NCH),
  localparam int AW   = CW + 1,
  localparam int NENT = 2 * NCH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  input  logic [CW-1:0] chan_i,
  output logic [DW-1:0] up_o,
  output logic [DW-1:0] lo_o
);
  logic [NENT*DW-1:0] flat;

  // entry 2c is the lower limit of channel c, 2c+1 the upper
  for (genvar g = 0; g < NENT; g++) begin : g_ent
    logic [DW-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             ent_q <= '0;
      else if (we_i && waddr_i == AW'(g))      ent_q <= wdata_i;
    end
    assign flat[g*DW +: DW] = ent_q;
  end

  assign rdata_o = flat[int'(raddr_i)*DW +: DW];
  assign up_o    = flat[int'({chan_i, 1'b1})*DW +: DW];
  assign lo_o    = flat[int'({chan_i, 1'b0})*DW +: DW];

  assert_readback_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> flat[int'($past(waddr_i))*DW +: DW] == $past(wdata_i));
endmodule

// File: rtl/win_window_cmp.sv
module win_window_cmp #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] smp_i,
  input  logic [DW-1:0] up_i,
  input  logic [DW-1:0] lo_i,
  output logic          above_o,
  output logic          viol_o
);
  logic below;
  assign above_o = smp_i > up_i;
  assign below   = smp_i < lo_i;
  assign viol_o  = above_o | below;
endmodule

// File: rtl/win_flag_unit.sv
module win_flag_unit #(
  parameter int NCH = 8,
  localparam int CW = $clog2(NCH),
  localparam int TW = CW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           first_i,
  input  logic           hit_i,
  input  logic [CW-1:0]  bit_i,
  input  logic [CW-1:0]  chan_i,
  input  logic           upper_i,
  input  logic           done_i,
  input  logic           clr_i,
  output logic [NCH-1:0] status_o,
  output logic [TW-1:0]  tag_o,
  output logic           irq_o
);
  logic [NCH-1:0] status_q;
  logic [TW-1:0]  tag_q;
  logic           irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      tag_q    <= '0;
      irq_q    <= 1'b0;
    end else if (clr_i) begin
      status_q <= '0;
      tag_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (first_i) begin
        status_q[NCH-1] <= 1'b1;
        tag_q           <= {upper_i, chan_i};
      end
      if (hit_i)  status_q[bit_i] <= 1'b1;
      if (done_i) irq_q <= 1'b1;
    end
  end

  assign status_o = status_q;
  assign tag_o    = tag_q;
  assign irq_o    = irq_q;

  assert_first_msb_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_i && !clr_i |=> status_q[NCH-1]);
  assert_irq_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !clr_i |=> irq_q);
  assert_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (status_q == '0 && tag_q == '0 && !irq_q));
  assert_irq_msb_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> status_q[NCH-1]);
endmodule

// File: rtl/win_watch_seq.sv
module win_watch_seq
  import win_watch_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 8,
  parameter int RW  = 12,
  localparam int CW   = $clog2(NCH),
  localparam int AW   = CW + 1,
  localparam int TW   = CW + 1,
  localparam int NENT = 2 * NCH
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_valid_i,
  output logic           cmd_ready_o,
  input  logic [2:0]     cmd_op_i,
  input  logic [CW-1:0]  cmd_chan_i,
  input  logic           cmd_sel_i,
  input  logic [DW-1:0]  cmd_wdata_i,
  output logic           rsp_valid_o,
  output logic [RW-1:0]  rsp_data_o,
  input  logic           smp_valid_i,
  output logic           smp_ready_o,
  output logic [CW-1:0]  smp_chan_o,
  input  logic [DW-1:0]  smp_data_i,
  output logic           conv_valid_o,
  output logic [CW-1:0]  conv_chan_o,
  output logic [DW-1:0]  conv_data_o,
  output logic           rf_we_o,
  output logic [AW-1:0]  rf_waddr_o,
  output logic [DW-1:0]  rf_wdata_o,
  output logic [AW-1:0]  rf_raddr_o,
  input  logic [DW-1:0]  rf_rdata_i,
  output logic [DW-1:0]  held_smp_o,
  input  logic           viol_i,
  input  logic           above_i,
  output logic           first_o,
  output logic           hit_o,
  output logic [CW-1:0]  bit_o,
  output logic           upper_o,
  output logic           done_o,
  output logic           clr_o,
  input  logic [NCH-1:0] status_i,
  input  logic [TW-1:0]  tag_i,
  input  logic           irq_i
);
  st_e           st_q;
  logic [CW-1:0] chan_q, chan_nxt, left_q;
  logic [AW-1:0] idx_q;
  logic [1:0]    slot_q;
  logic          pass_q;
  logic [DW-1:0] smp_q;
  logic          rsp_valid_q, conv_valid_q;
  logic [RW-1:0] rsp_data_q;
  logic [CW-1:0] conv_chan_q;
  logic [DW-1:0] conv_data_q;
  op_e           op;
  logic          cmd_fire, can_exec, exec, flag_rd, smp_fire, eval, in_scan;

  assign op       = op_e'(cmd_op_i);
  assign in_scan  = (st_q == S_W_REQ) || (st_q == S_W_CMP);
  assign can_exec = (st_q == S_IDLE) || (st_q == S_AUTO) || (in_scan && !pass_q);
  assign cmd_ready_o = can_exec || (st_q == S_WRALL) || (st_q == S_FLAG);
  assign cmd_fire = cmd_valid_i && cmd_ready_o;
  assign exec     = cmd_fire && can_exec;
  assign flag_rd  = cmd_fire && (st_q == S_FLAG) && (op == OP_RD_FLAGS);

  assign smp_ready_o = ((st_q == S_CONV1) || (st_q == S_AUTO) || (st_q == S_W_REQ)) && !exec;
  assign smp_fire    = smp_valid_i && smp_ready_o;
  assign smp_chan_o  = chan_q;
  assign chan_nxt    = (chan_q == CW'(NCH-1)) ? '0 : chan_q + 1'b1;

  // both limit slots done: judge the held sample
  assign eval    = (st_q == S_W_CMP) && (slot_q == 2'd3) && !exec;
  assign first_o = eval && !pass_q && viol_i;
  assign hit_o   = eval && pass_q && viol_i;
  assign bit_o   = CW'(NCH-1) - left_q;
  assign upper_o = above_i;
  assign done_o  = eval && pass_q && (left_q == CW'(1));
  assign clr_o   = (exec && op == OP_RD_FLAGS) || flag_rd;
  assign held_smp_o = smp_q;

  assign rf_we_o    = (exec && op == OP_WR_ONE) || (cmd_fire && st_q == S_WRALL);
  assign rf_waddr_o = (st_q == S_WRALL) ? idx_q : {cmd_chan_i, cmd_sel_i};
  assign rf_wdata_o = cmd_wdata_i;
  assign rf_raddr_o = (st_q == S_RDALL) ? idx_q : {cmd_chan_i, cmd_sel_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q  <= 1'b0;
      rsp_data_q   <= '0;
      conv_valid_q <= 1'b0;
      conv_chan_q  <= '0;
      conv_data_q  <= '0;
    end else begin
      rsp_valid_q  <= 1'b0;
      conv_valid_q <= 1'b0;
      if ((exec && op == OP_RD_ONE) || st_q == S_RDALL) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= RW'(rf_rdata_i);
      end
      if (clr_o) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= RW'({tag_i, status_i});
      end
      if (smp_fire && (st_q == S_CONV1 || st_q == S_AUTO)) begin
        conv_valid_q <= 1'b1;
        conv_chan_q  <= chan_q;
        conv_data_q  <= smp_data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      chan_q <= '0;
      idx_q  <= '0;
      slot_q <= '0;
      left_q <= '0;
      pass_q <= 1'b0;
      smp_q  <= '0;
    end else if (exec) begin
      pass_q <= 1'b0;
      case (op)
        OP_WATCH:     begin st_q <= S_W_REQ; chan_q <= '0; end
        OP_WR_ALL:    begin st_q <= S_WRALL; idx_q <= '0; end
        OP_RD_ALL:    begin st_q <= S_RDALL; idx_q <= '0; end
        OP_CONV_ONE:  begin st_q <= S_CONV1; chan_q <= cmd_chan_i; end
        OP_CONV_AUTO: begin st_q <= S_AUTO;  chan_q <= '0; end
        default:      st_q <= S_IDLE;
      endcase
    end else begin
      case (st_q)
        S_WRALL: if (cmd_fire) begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == AW'(NENT-1)) st_q <= S_IDLE;
        end
        S_RDALL: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == AW'(NENT-1)) st_q <= S_IDLE;
        end
        S_CONV1: if (smp_fire) st_q <= S_IDLE;
        S_AUTO:  if (smp_fire) chan_q <= chan_nxt;
        S_W_REQ: if (smp_fire) begin
          smp_q  <= smp_data_i;
          slot_q <= '0;
          st_q   <= S_W_CMP;
        end
        S_W_CMP: begin
          slot_q <= slot_q + 1'b1;
          if (slot_q == 2'd3) begin
            chan_q <= chan_nxt;
            st_q   <= S_W_REQ;
            if (!pass_q) begin
              if (viol_i) begin
                pass_q <= 1'b1;
                left_q <= CW'(NCH-1);
              end
            end else begin
              left_q <= left_q - 1'b1;
              if (left_q == CW'(1)) begin
                pass_q <= 1'b0;
                st_q   <= S_FLAG;
              end
            end
          end
        end
        S_FLAG:  if (flag_rd) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_data_o   = rsp_data_q;
  assign conv_valid_o = conv_valid_q;
  assign conv_chan_o  = conv_chan_q;
  assign conv_data_o  = conv_data_q;

  assert_flag_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (!smp_ready_o && !conv_valid_o));
  assert_pass_locked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_o |=> !cmd_ready_o);
endmodule

// File: rtl/win_watch.sv
module win_watch
  import win_watch_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 8,
  localparam int CW = $clog2(NCH),
  localparam int TW = CW + 1,
  localparam int RW = (TW + NCH > DW) ? TW + NCH : DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic [2:0]    cmd_op_i,
  input  logic [CW-1:0] cmd_chan_i,
  input  logic          cmd_sel_i,
  input  logic [DW-1:0] cmd_wdata_i,
  output logic          rsp_valid_o,
  output logic [RW-1:0] rsp_data_o,
  input  logic          smp_valid_i,
  output logic          smp_ready_o,
  output logic [CW-1:0] smp_chan_o,
  input  logic [DW-1:0] smp_data_i,
  output logic          conv_valid_o,
  output logic [CW-1:0] conv_chan_o,
  output logic [DW-1:0] conv_data_o,
  output logic          irq_no
);
  localparam int AW = CW + 1;

  logic          rf_we;
  logic [AW-1:0] rf_waddr, rf_raddr;
  logic [DW-1:0] rf_wdata, rf_rdata, lim_up, lim_lo, held_smp;
  logic          above, viol, first, hit, upper, done, clr, irq;
  logic [CW-1:0] bit_idx;
  logic [NCH-1:0] status;
  logic [TW-1:0]  tag;

  win_limit_rf #(.NCH(NCH), .DW(DW)) u_rf (
    .clk_i, .rst_ni,
    .we_i(rf_we), .waddr_i(rf_waddr), .wdata_i(rf_wdata),
    .raddr_i(rf_raddr), .rdata_o(rf_rdata),
    .chan_i(smp_chan_o), .up_o(lim_up), .lo_o(lim_lo)
  );

  win_window_cmp #(.DW(DW)) u_cmp (
    .smp_i(held_smp), .up_i(lim_up), .lo_i(lim_lo),
    .above_o(above), .viol_o(viol)
  );

  win_flag_unit #(.NCH(NCH)) u_flags (
    .clk_i, .rst_ni,
    .first_i(first), .hit_i(hit), .bit_i(bit_idx), .chan_i(smp_chan_o),
    .upper_i(upper), .done_i(done), .clr_i(clr),
    .status_o(status), .tag_o(tag), .irq_o(irq)
  );

  win_watch_seq #(.NCH(NCH), .DW(DW), .RW(RW)) u_seq (
    .clk_i, .rst_ni,
    .cmd_valid_i, .cmd_ready_o, .cmd_op_i, .cmd_chan_i, .cmd_sel_i, .cmd_wdata_i,
    .rsp_valid_o, .rsp_data_o,
    .smp_valid_i, .smp_ready_o, .smp_chan_o, .smp_data_i,
    .conv_valid_o, .conv_chan_o, .conv_data_o,
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata),
    .held_smp_o(held_smp), .viol_i(viol), .above_i(above),
    .first_o(first), .hit_o(hit), .bit_o(bit_idx), .upper_o(upper),
    .done_o(done), .clr_o(clr),
    .status_i(status), .tag_i(tag), .irq_i(irq)
  );

  assign irq_no = ~irq;
endmodule

// File: tb/sim_win_watch.sv
module sim_win_watch;
  localparam int CLK_P = 10;
  localparam int NCH = 8;
  localparam int DW  = 8;
  localparam int CW  = 3;
  localparam int RW  = 12;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic cmd_ready_o;
  logic [2:0] cmd_op_i = '0;
  logic [CW-1:0] cmd_chan_i = '0;
  logic cmd_sel_i = 1'b0;
  logic [DW-1:0] cmd_wdata_i = '0;
  logic rsp_valid_o;
  logic [RW-1:0] rsp_data_o;
  logic smp_valid_i = 1'b0;
  logic smp_ready_o;
  logic [CW-1:0] smp_chan_o;
  logic [DW-1:0] smp_data_i;
  logic conv_valid_o;
  logic [CW-1:0] conv_chan_o;
  logic [DW-1:0] conv_data_o;
  logic irq_no;

  always #(CLK_P/2) clk_i = ~clk_i;

  logic [7:0] lim_m [16];
  logic [7:0] ch_val [8];
  assign smp_data_i = ch_val[smp_chan_o];

  win_watch u0 (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_ready_o, .cmd_op_i, .cmd_chan_i,
    .cmd_sel_i, .cmd_wdata_i, .rsp_valid_o, .rsp_data_o, .smp_valid_i,
    .smp_ready_o, .smp_chan_o, .smp_data_i, .conv_valid_o, .conv_chan_o,
    .conv_data_o, .irq_no
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit rnd_valid = 1'b0, finished = 1'b0;
  logic [RW-1:0] rsp_buf [64];
  logic [10:0]   conv_buf [64];
  int hs_cyc [64];
  int hs_ch [64];
  int rsp_n = 0, conv_n = 0, hs_n = 0;

  always @(posedge clk_i) cyc++;
  always @(posedge clk_i) begin
    #1;
    smp_valid_i = rnd_valid ? (($urandom % 4) != 0) : 1'b1;
  end
  always @(negedge clk_i) begin
    if (rsp_valid_o) begin if (rsp_n < 64) rsp_buf[rsp_n] = rsp_data_o; rsp_n++; end
    if (conv_valid_o) begin if (conv_n < 64) conv_buf[conv_n] = {conv_chan_o, conv_data_o}; conv_n++; end
    if (smp_valid_i && smp_ready_o) begin
      if (hs_n < 64) begin hs_cyc[hs_n] = cyc; hs_ch[hs_n] = int'(smp_chan_o); end
      hs_n++;
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog timeout act=running exp=done");
    report();
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic send(logic [2:0] op, int ch, bit sel, logic [7:0] d);
    @(posedge clk_i); #1;
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_chan_i = CW'(ch);
    cmd_sel_i = sel; cmd_wdata_i = d;
    while (!cmd_ready_o) begin @(posedge clk_i); #1; end
    @(posedge clk_i); #1;
    cmd_valid_i = 1'b0;
  endtask

  task automatic rd_one(int ch, bit sel, output logic [7:0] v);
    rsp_n = 0;
    send(3'd3, ch, sel, 8'h00);
    tick(2);
    chk("R2", "rd_one beats", rsp_n, 1);
    chk("R2", "rd_one upper bits", rsp_buf[0][11:8], 0);
    v = rsp_buf[0][7:0];
  endtask

  task automatic wr_all();
    send(3'd2, 0, 0, 8'h00);
    for (int k = 0; k < 16; k++) send(3'($urandom % 8), 0, 0, lim_m[k]);
  endtask

  task automatic rd_all(string req);
    rsp_n = 0;
    send(3'd4, 0, 0, 8'h00);
    tick(20);
    chk(req, "rd_all beats", rsp_n, 16);
    for (int k = 0; k < 16; k++) chk(req, $sformatf("rd_all entry %0d", k), rsp_buf[k], {4'h0, lim_m[k]});
  endtask

  task automatic rd_flags(output logic [RW-1:0] v);
    rsp_n = 0;
    send(3'd7, 0, 0, 8'h00);
    tick(2);
    chk("R12", "flag read beats", rsp_n, 1);
    v = rsp_buf[0];
  endtask

  task automatic wait_irq(output bit got);
    got = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      tick(1);
      if (!irq_no) begin got = 1'b1; break; end
    end
  endtask

  function automatic bit abv(int c);
    return ch_val[c] > lim_m[2*c+1];
  endfunction
  function automatic bit vio(int c);
    return (ch_val[c] > lim_m[2*c+1]) || (ch_val[c] < lim_m[2*c]);
  endfunction
  function automatic int first_bad();
    for (int c = 0; c < NCH; c++) if (vio(c)) return c;
    return -1;
  endfunction
  function automatic logic [7:0] exp_stat(int f);
    logic [7:0] s;
    s[7] = 1'b1;
    for (int j = 0; j < 7; j++) s[j] = vio((f + 1 + j) % 8);
    return s;
  endfunction
  function automatic logic [7:0] vio_vec();
    logic [7:0] v;
    for (int c = 0; c < 8; c++) v[c] = vio(c);
    return v;
  endfunction
  function automatic logic [7:0] rotl(logic [7:0] s, int k);
    logic [15:0] d;
    d = {s, s} << (k % 8);
    return d[15:8];
  endfunction

  // run a watchdog scan expected to flag, then check flags
  task automatic watch_and_check(string tag_txt, bit probe_ignore);
    bit got;
    int f;
    logic [RW-1:0] fl;
    logic [7:0] old, rb;
    f = first_bad();
    send(3'd0, 0, 0, 8'h00);
    wait_irq(got);
    chk("R10", {tag_txt, " irq asserted"}, got, 1);
    @(negedge clk_i);
    chk("R10", {tag_txt, " sampling stopped"}, smp_ready_o, 0);
    if (probe_ignore) begin
      rd_one_silent(old);
      rsp_n = 0; conv_n = 0;
      send(3'd1, 2, 1, ~old);
      send(3'd5, 4, 0, 8'h00);
      send(3'd0, 0, 0, 8'h00);
      tick(6);
      chk("R11", "no response while flagged", rsp_n, 0);
      chk("R11", "no conversion while flagged", conv_n, 0);
      chk("R11", "irq held", irq_no, 0);
    end
    rd_flags(fl);
    chk("R9", {tag_txt, " tag"}, fl[11:8], {abv(f), 3'(f)});
    chk("R10", {tag_txt, " status"}, fl[7:0], exp_stat(f));
    chk("R10", {tag_txt, " rotated status"}, rotl(fl[7:0], f + 1), vio_vec());
    tick(1);
    chk("R12", {tag_txt, " irq released"}, irq_no, 1);
    if (probe_ignore) begin
      rd_one(2, 1, rb);
      chk("R11", "limit untouched", rb, lim_m[5]);
      rd_flags(fl);
      chk("R12", "flags cleared", fl, 0);
    end
  endtask

  task automatic rd_one_silent(output logic [7:0] v);
    v = lim_m[5];
  endtask

  initial begin
    logic [7:0] v;
    logic [RW-1:0] fl;
    int hs0, c, lo, up, span;
    void'($urandom(32'h5eed_0a1c));
    for (int k = 0; k < 16; k++) lim_m[k] = 8'h00;
    for (int k = 0; k < 8; k++) ch_val[k] = 8'h00;
    tick(3);
    chk("R1", "irq_no in reset", irq_no, 1);
    chk("R1", "rsp_valid in reset", rsp_valid_o, 0);
    chk("R1", "conv_valid in reset", conv_valid_o, 0);
    chk("R1", "cmd_ready in reset", cmd_ready_o, 1);
    rst_ni = 1'b1;
    tick(2);
    rd_all("R1");

    // R2 single write/read
    for (int i = 0; i < 8; i++) begin
      c = $urandom % 8;
      lo = $urandom % 2;
      v = 8'($urandom);
      send(3'd1, c, lo[0], v);
      lim_m[2*c + lo] = v;
      rd_one(c, lo[0], v);
      chk("R2", $sformatf("readback ch%0d sel%0d", c, lo), v, lim_m[2*c + lo]);
    end

    // R3/R4 burst
    for (int k = 0; k < 16; k++) lim_m[k] = 8'($urandom);
    wr_all();
    rd_all("R3 R4");

    // R5 single conversion
    for (int k = 0; k < 8; k++) ch_val[k] = 8'($urandom);
    conv_n = 0;
    send(3'd5, 5, 0, 8'h00);
    tick(8);
    chk("R5", "conv beats", conv_n, 1);
    chk("R5", "conv chan/data", conv_buf[0], {3'd5, ch_val[5]});

    // R6 auto conversion
    rnd_valid = 1'b1;
    conv_n = 0;
    send(3'd6, 0, 0, 8'h00);
    tick(50);
    send(3'd7, 0, 0, 8'h00);
    tick(3);
    hs0 = conv_n;
    chk("R6", "auto produced beats", (conv_n > 8) ? 1 : 0, 1);
    for (int k = 0; k < conv_n && k < 64; k++)
      chk("R6", $sformatf("auto beat %0d", k), conv_buf[k], {3'(k % 8), ch_val[k % 8]});
    tick(10);
    chk("R6", "auto stopped", conv_n, hs0);

    // R7/R13 scan with no violation, valid held high
    rnd_valid = 1'b0;
    for (int k = 0; k < 8; k++) begin lim_m[2*k] = 8'h00; lim_m[2*k+1] = 8'hff; end
    wr_all();
    hs_n = 0;
    send(3'd0, 0, 0, 8'h00);
    tick(80);
    chk("R7", "irq high without violation", irq_no, 1);
    chk("R7", "scan progressed", (hs_n >= 12) ? 1 : 0, 1);
    for (int k = 0; k < 12; k++) chk("R7", $sformatf("scan order %0d", k), hs_ch[k], k % 8);
    for (int k = 1; k < 12; k++) chk("R13", $sformatf("check spacing %0d", k), hs_cyc[k] - hs_cyc[k-1], 5);
    rd_flags(fl);
    chk("R7", "no flags after clean scan", fl, 0);
    hs0 = hs_n;
    tick(10);
    chk("R7", "scan ended by command", hs_n, hs0);

    // R9 both limits crossed: upper wins
    for (int k = 0; k < 8; k++) ch_val[k] = 8'h40;
    lim_m[6] = 8'd200; lim_m[7] = 8'd100;
    wr_all();
    ch_val[3] = 8'd150;
    watch_and_check("R9 both-crossed", 1'b0);

    // R8 boundary: equal values never violate
    for (int k = 0; k < 8; k++) begin
      lim_m[2*k] = 8'd50; lim_m[2*k+1] = 8'd90;
      ch_val[k] = (k % 2) ? 8'd50 : 8'd90;
    end
    ch_val[6] = 8'd49;
    wr_all();
    watch_and_check("R8 boundary", 1'b0);
    chk("R8", "single boundary failure", vio_vec(), 8'h40);

    // random trials
    rnd_valid = 1'b1;
    for (int t = 0; t < 24; t++) begin
      for (int k = 0; k < 8; k++) begin
        lo = $urandom % 128;
        up = lo + ($urandom % 128);
        lim_m[2*k] = 8'(lo); lim_m[2*k+1] = 8'(up);
        span = $urandom % 10;
        if (span < 2) ch_val[k] = 8'(up + 1 + ($urandom % (255 - up)));
        else if (span < 4 && lo > 0) ch_val[k] = 8'(lo - 1 - ($urandom % lo));
        else if (span == 4) ch_val[k] = 8'(up);
        else ch_val[k] = 8'(lo + ($urandom % (up - lo + 1)));
      end
      c = $urandom % 8;
      ch_val[c] = (lim_m[2*c+1] < 8'hff) ? lim_m[2*c+1] + 8'd1 : 8'h00;
      if (ch_val[c] == 8'h00) lim_m[2*c] = 8'h01;
      wr_all();
      watch_and_check($sformatf("trial %0d", t), (t % 3) == 0);
    end

    tick(5);
    report();
  end
endmodule